// File: doc/BRIEF.md
# Frame-Synchronised Serial Receiver

This block takes a serial bit stream that arrives with its own bit clock and a frame-sync strobe, and turns it into parallel words held in a small receive buffer. The bit clock, frame sync and data inputs are oversampled by the system clock. They are assumed to be already synchronised to it, and each bit-clock level must last at least one system clock. A polarity input chooses which bit-clock edge is the capture edge. A 2-bit delay input sets how many capture edges separate the frame sync from the first data bit. A mode input selects where the data is taken. In full-cycle mode it is taken at the capture edge itself. In half-cycle mode it is taken at the opposite edge that precedes it.

Each frame carries one word of `WORD_W` bits, most significant bit first. A completed word is pushed into a FIFO of `DEPTH` entries. The FIFO shows its oldest entry and its occupancy count, and it is drained by a pop strobe.

A receive-off input discards frames whole. A discarded frame produces no word and does not raise overflow, but its frame sync is still reported. Once the receive-off input is cleared, reception resumes from the next frame sync. A word that completes while the buffer is full is lost, and it sets a sticky overflow flag.

Top module: `framed_rx`

## Requirements
- R1: After reset, `rd_valid`, `level`, `ovf`, `fs_seen` and `word_stb` are all 0.
- R2: The capture edge is the rising edge of `bclk` when `cap_rise` is 1 and the falling edge when it is 0 (the reset-style default).
- R3: With the frame sync seen at capture edge k and `dly` = d, the first data bit is taken at capture edge k+d for d in 0..2. A `dly` value of 3 behaves as 2.
- R4: A frame's `WORD_W` bits form one word, most significant bit first. When the word is stored, `word_stb` is high for exactly one clock.
- R5: With `full_cycle` = 1, each bit is the `sdata` value at the capture edge. With `full_cycle` = 0, each bit is the `sdata` value at the opposite edge immediately before that capture edge.
- R6: A frame whose sync arrives while `rx_off` = 1 is discarded entirely. `level`, `word_stb` and `ovf` stay unchanged.
- R7: Each detected frame sync gives a one-clock pulse on `fs_seen`, whether or not `rx_off` is set.
- R8: Clearing `rx_off` in the middle of a discarded frame does not revive that frame. The next frame sync starts a received frame.
- R9: The buffer is first-in first-out. `rd_data` is the oldest word, `rd_valid` is 1 exactly when `level` is nonzero, a `pop` removes one word, and `level` never exceeds `DEPTH`.
- R10: A word that completes while `level` = `DEPTH` and `pop` is low is dropped, and the buffer contents are unchanged. `ovf` is set and stays 1 until reset.
- R11: A frame sync is detected only when `fsync` is 1 at a capture edge and was 0 at the previous capture edge. Holding `fsync` high does not restart a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk | input | 1 | Serial bit clock, oversampled |
| fsync | input | 1 | Receive frame sync |
| sdata | input | 1 | Serial data |
| cap_rise | input | 1 | 1: capture on rising edge, 0: falling edge |
| full_cycle | input | 1 | 1: full-cycle data timing, 0: half-cycle |
| dly | input | 2 | Capture edges from frame sync to first bit (3 acts as 2) |
| rx_off | input | 1 | Discard frames whose sync arrives while high |
| pop | input | 1 | Remove the oldest word from the buffer |
| rd_data | output | WORD_W | Oldest buffered word |
| rd_valid | output | 1 | Buffer not empty |
| level | output | $clog2(DEPTH+1) | Number of buffered words |
| word_stb | output | 1 | One-clock pulse per stored word |
| fs_seen | output | 1 | One-clock pulse per detected frame sync |
| ovf | output | 1 | Sticky overflow flag |

## Verification
A word is stored at the system clock edge that sees the capture edge of its last bit. `word_stb`, `level` and `rd_data` show it one clock later, and `fs_seen` pulses one clock after the capture edge that carries the sync. The bench builds each bit period from eight system clocks, with the opposite edge at the first clock and the capture edge at the fifth. It places the correct bit only in the half of the period that the selected mode samples, so a wrong edge or a wrong mode shows up as a wrong data bit. Pulses are counted on falling system-clock edges, and data, level and flags are checked only after a trailing idle period, when every result is due.

// File: rtl/framed_rx_pkg.sv
// framed_rx_pkg: shared types and helpers for the frame-synchronised receiver.
// Assumes nothing beyond a 2-bit delay encoding.
package framed_rx_pkg;
    typedef logic [1:0] dly_t;

    // Limit the data delay to the supported range 0..2.
    function automatic dly_t clamp_dly(input dly_t d);
        return (d == 2'd3) ? 2'd2 : d;
    endfunction
endpackage

// File: rtl/framed_rx_edge.sv
// framed_rx_edge: finds capture and opposite edges of the oversampled bit
// clock, detects frame-sync rises between capture edges and selects the data
// bit for full- or half-cycle timing.
// Assumes bclk, fsync and sdata are synchronous to clk and each bclk level
// lasts at least one clk.
module framed_rx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic fsync,
    input  logic sdata,
    input  logic cap_rise,
    input  logic full_cycle,
    output logic cap_evt,
    output logic fs_det,
    output logic bit_val
);
    logic bclk_q;
    logic fs_prev;
    logic mid_bit;
    logic rise;
    logic fall;
    logic opp_evt;

    // Decode edges and choose which sampled data value is the bit.
    always_comb begin
        rise    = bclk & ~bclk_q;
        fall    = ~bclk & bclk_q;
        cap_evt = cap_rise ? rise : fall;
        opp_evt = cap_rise ? fall : rise;
        fs_det  = cap_evt & fsync & ~fs_prev;
        bit_val = full_cycle ? sdata : mid_bit;
    end

    // Track the previous bclk level, the half-cycle data sample and the sync level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q  <= 1'b0;
            fs_prev <= 1'b0;
            mid_bit <= 1'b0;
        end else begin
            bclk_q <= bclk;
            if (opp_evt) mid_bit <= sdata;
            if (cap_evt) fs_prev <= fsync;
        end
    end
endmodule

// File: rtl/framed_rx_frame.sv
// framed_rx_frame: counts the data delay after a frame sync, shifts bits in
// MSB first and flags word completion together with the frame's keep
// decision, which is fixed at the frame sync.
// Assumes one word per frame; a new sync restarts the frame.
module framed_rx_frame
    import framed_rx_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_evt,
    input  logic              fs_det,
    input  logic              bit_val,
    input  dly_t              dly,
    input  logic              rx_off,
    output logic              word_done,
    output logic              word_keep,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W = $clog2(WORD_W);

    logic             collecting;
    logic             keep_q;
    dly_t             skip;
    logic [CNT_W-1:0] cnt;
    logic [WORD_W-1:0] sh;
    logic             go;
    dly_t             skip_n;
    logic [CNT_W-1:0] cnt_n;
    logic             take;

    // Work out this edge's delay state, bit position and completion.
    always_comb begin
        go        = fs_det | collecting;
        skip_n    = fs_det ? clamp_dly(dly) : skip;
        cnt_n     = fs_det ? '0 : cnt;
        take      = cap_evt & go & (skip_n == 2'd0);
        word      = {sh[WORD_W-2:0], bit_val};
        word_done = take & (cnt_n == CNT_W'(WORD_W - 1));
        word_keep = fs_det ? ~rx_off : keep_q;
    end

    // Advance the frame state on each capture edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            collecting <= 1'b0;
            keep_q     <= 1'b0;
            skip       <= '0;
            cnt        <= '0;
            sh         <= '0;
        end else if (cap_evt) begin
            if (fs_det) begin
                collecting <= 1'b1;
                keep_q     <= ~rx_off;
                cnt        <= '0;
            end
            if (go) begin
                if (skip_n != 2'd0) begin
                    skip <= skip_n - 2'd1;
                end else begin
                    skip <= '0;
                    sh   <= word;
                    cnt  <= cnt_n + 1'b1;
                    if (word_done) collecting <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/framed_rx_fifo.sv
// framed_rx_fifo: small synchronous FIFO with occupancy count.
// Assumes the caller never pushes when full unless it pops in the same cycle.
module framed_rx_fifo #(
    parameter int WORD_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  logic [WORD_W-1:0]          din,
    output logic [WORD_W-1:0]          dout,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp;
    logic [AW-1:0]     rp;
    logic              do_pop;

    // Status and read port.
    always_comb begin
        empty  = (level == '0);
        full   = (level == LW'(DEPTH));
        do_pop = pop & ~empty;
        dout   = mem[rp];
    end

    // Store pushed words.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    // Move pointers and keep the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (push)   wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (push && !do_pop)      level <= level + 1'b1;
            else if (!push && do_pop) level <= level - 1'b1;
        end
    end
endmodule

// File: rtl/framed_rx.sv
// framed_rx: frame-synchronised serial receiver top. Joins the edge finder,
// the frame assembler and the receive FIFO; owns the overflow and pulse flags.
// Assumes serial inputs are already synchronous to clk.
module framed_rx
    import framed_rx_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int DEPTH  = 4,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk,
    input  logic              fsync,
    input  logic              sdata,
    input  logic              cap_rise,
    input  logic              full_cycle,
    input  logic [1:0]        dly,
    input  logic              rx_off,
    input  logic              pop,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [LW-1:0]     level,
    output logic              word_stb,
    output logic              fs_seen,
    output logic              ovf
);
    logic              cap_evt;
    logic              fs_det;
    logic              bit_val;
    logic              word_done;
    logic              word_keep;
    logic [WORD_W-1:0] word;
    logic              push;
    logic              full;
    logic              empty;
    logic              lost;

    framed_rx_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk       (bclk),
        .fsync      (fsync),
        .sdata      (sdata),
        .cap_rise   (cap_rise),
        .full_cycle (full_cycle),
        .cap_evt    (cap_evt),
        .fs_det     (fs_det),
        .bit_val    (bit_val)
    );

    framed_rx_frame #(.WORD_W(WORD_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_evt   (cap_evt),
        .fs_det    (fs_det),
        .bit_val   (bit_val),
        .dly       (dly),
        .rx_off    (rx_off),
        .word_done (word_done),
        .word_keep (word_keep),
        .word      (word)
    );

    // Store a kept word unless the buffer is full without a pop.
    always_comb begin
        push     = word_done & word_keep & (~full | pop);
        lost     = word_done & word_keep & full & ~pop;
        rd_valid = ~empty;
    end

    framed_rx_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (word),
        .dout  (rd_data),
        .level (level),
        .full  (full),
        .empty (empty)
    );

    // Register the pulse outputs and hold overflow until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_stb <= 1'b0;
            fs_seen  <= 1'b0;
            ovf      <= 1'b0;
        end else begin
            word_stb <= push;
            fs_seen  <= fs_det;
            if (lost) ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/framed_rx_chk.sv
// framed_rx_chk: property checker for framed_rx, attached by bind.
// Assumes bit-clock levels last at least one clk, so pulses cannot repeat.
module framed_rx_chk #(
    parameter int DEPTH = 4,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_valid,
    input logic [LW-1:0] level,
    input logic          word_stb,
    input logic          fs_seen,
    input logic          ovf
);
    AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == (level != '0)); // R9
    AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH)); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf); // R10
    AST_OVF_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> level == LW'(DEPTH)); // R10
    AST_STB_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |-> rd_valid); // R4
    AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |=> !word_stb); // R4
    AST_FS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fs_seen |=> !fs_seen); // R7
endmodule

bind framed_rx framed_rx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_valid (rd_valid),
    .level    (level),
    .word_stb (word_stb),
    .fs_seen  (fs_seen),
    .ovf      (ovf)
);

// File: tb/framed_rx_test.sv
`timescale 1ns/1ps
// framed_rx_test: sweeps edge polarity, cycle mode and delay, then checks
// discard, re-enable, held sync, FIFO order and overflow.
module framed_rx_test;
    localparam int W     = 8;
    localparam int DEPTH = 4;
    localparam int LW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk = 1'b0, fsync = 1'b0, sdata = 1'b0;
    logic cap_rise = 1'b0, full_cycle = 1'b1, rx_off = 1'b0, pop = 1'b0;
    logic [1:0] dly = 2'd1;
    logic [W-1:0]  rd_data;
    logic          rd_valid, word_stb, fs_seen, ovf;
    logic [LW-1:0] level;

    int checks = 0, fails = 0, stb_cnt = 0, fs_cnt = 0;

    always #4 clk = ~clk;

    framed_rx #(.WORD_W(W), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .sdata(sdata),
        .cap_rise(cap_rise), .full_cycle(full_cycle), .dly(dly), .rx_off(rx_off),
        .pop(pop), .rd_data(rd_data), .rd_valid(rd_valid), .level(level),
        .word_stb(word_stb), .fs_seen(fs_seen), .ovf(ovf)
    );

    // Count output pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n && word_stb) stb_cnt++;
        if (rst_n && fs_seen)  fs_cnt++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One bit period of 8 clocks: opposite edge at clock 0, capture edge at clock 4.
    task automatic period(input bit fs_v, input bit b);
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            bclk  = (c < 4) ? ~cap_rise : cap_rise;
            fsync = fs_v;
            if (c < 4) sdata = full_cycle ? ~b : b;
            else       sdata = full_cycle ? b : ~b;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) period(1'b0, 1'b0);
    endtask

    // Send one frame: sync held fs_len periods, rx_off cleared at period clr_at.
    task automatic send(input logic [W-1:0] w, input int fs_len, input int clr_at);
        int d;
        d = (dly == 2'd3) ? 2 : int'(dly);
        for (int p = 0; p < d + W; p++) begin
            int idx;
            bit b;
            if (p == clr_at) rx_off = 1'b0;
            idx = p - d;
            b = (idx >= 0 && idx < W) ? w[W-1-idx] : 1'b0;
            period(p < fs_len, b);
        end
        idle(1);
    endtask

    task automatic do_pop();
        @(negedge clk) pop = 1'b1;
        @(negedge clk) pop = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int s0, f0;
        logic [W-1:0] w;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 level", level, 0);
        chk("R1 ovf", ovf, 0);
        chk("R1 fs_seen", fs_seen, 0);
        chk("R1 word_stb", word_stb, 0);

        // R2, R3, R5: sweep capture edge, cycle mode and delay
        for (int cr = 0; cr < 2; cr++)
            for (int fc = 0; fc < 2; fc++)
                for (int d = 0; d < 4; d++) begin
                    cap_rise = cr[0]; full_cycle = fc[0]; dly = d[1:0];
                    idle(2);
                    w  = W'((cr * 8 + fc * 4 + d) * 29 + 11);
                    s0 = stb_cnt; f0 = fs_cnt;
                    send(w, 1, -1);
                    chk("R2,R3,R5 word", rd_data, w);
                    chk("R9 level", level, 1);
                    chk("R4 word_stb pulses", stb_cnt - s0, 1);
                    chk("R7 fs_seen pulses", fs_cnt - f0, 1);
                    do_pop();
                    chk("R9 level after pop", level, 0);
                end

        cap_rise = 1'b0; full_cycle = 1'b1; dly = 2'd1;
        idle(2);

        // R6, R7: disabled frame dropped, sync still reported
        rx_off = 1'b1;
        s0 = stb_cnt; f0 = fs_cnt;
        send(8'hA5, 1, -1);
        chk("R6 level", level, 0);
        chk("R6 ovf", ovf, 0);
        chk("R6 word_stb", stb_cnt - s0, 0);
        chk("R7 fs_seen while off", fs_cnt - f0, 1);

        // R8: clear mid-frame, frame still lost; next frame received
        s0 = stb_cnt;
        send(8'h3C, 1, 3);
        chk("R8 level", level, 0);
        chk("R8 word_stb", stb_cnt - s0, 0);
        send(8'hC3, 1, -1);
        chk("R8 next frame", rd_data, 8'hC3);
        chk("R8 level", level, 1);
        do_pop();

        // R11: sync held high for three periods counts once
        f0 = fs_cnt;
        send(8'h5A, 3, -1);
        chk("R11 word", rd_data, 8'h5A);
        chk("R11 fs count", fs_cnt - f0, 1);
        do_pop();

        // R9, R10: fill, overflow, drain in order
        for (int k = 0; k < DEPTH; k++) send(W'(8'h10 + k * 17), 1, -1);
        chk("R9 full level", level, DEPTH);
        chk("R10 ovf before", ovf, 0);
        s0 = stb_cnt;
        send(8'hEE, 1, -1);
        chk("R10 ovf set", ovf, 1);
        chk("R10 level kept", level, DEPTH);
        chk("R10 no stb", stb_cnt - s0, 0);
        for (int k = 0; k < DEPTH; k++) begin
            chk("R9 order", rd_data, W'(8'h10 + k * 17));
            do_pop();
        end
        chk("R9 drained", level, 0);
        chk("R10 ovf sticky", ovf, 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule